// File: doc/BRIEF.md
# Root-Hub Downstream Port Status Controller

This block keeps the live status and the sticky change flags of one downstream port of a USB host root hub. Host software reads a 32-bit status word. It sends port commands by writing that same word: power on or off, enable or disable, suspend, resume and port reset. The block times the port reset and the resume sequence from a 1 kHz tick. While a sequence runs, it drives control strobes for reset signalling, resume signalling and the low-speed end-of-packet. When a sequence ends, or when the connect, enable or overcurrent state changes, the block raises a change flag. That flag stays set until software writes 1 to its bit.

Port commands that arrive while a bus transaction is in progress are held in a one-entry pending slot. They take effect on the first cycle in which the transaction-busy input is low. All durations are parameters, so short values can be used in simulation.

Top module: `usb_port_status`

## Requirements
- R1: The status word has these fields: connected at bit 0, enabled at bit 1, suspended at bit 2, overcurrent at bit 3, reset active at bit 4, powered at bit 8, low-speed device at bit 9. Change flags are at bits 16 (connect), 17 (enable), 18 (resume done), 19 (overcurrent) and 20 (reset done). Bits 31:21, 15:10 and 7:5 always read 0, whatever was written.
- R2: Bit 0 follows the connect line one cycle late, but only while the port is powered. Bit 9 is the low-speed line ANDed with connect. Any change of bit 0 sets the connect-change flag.
- R3: Writing 1 at bit 8 powers the port. Writing 1 at bit 9 removes power, and this wins when both bits are 1.
- R4: Writing 1 at bit 4 while the port is powered, connected and idle starts a reset. Bit 4 and reset_drive stay high for RESET_MS ticks. When the reset ends, the port is enabled, it is no longer suspended, and the reset-change flag is set.
- R5: Writing 1 at bit 3 starts a resume, which runs in this order: resume_drive for RESUME_MS ticks, then eop_drive for EOP_CYC clock cycles, then RESYNC_MS ticks. Only after all three does bit 2 clear and the resume-change flag set. At most one of the three strobes is high at a time.
- R6: A resume command is ignored unless the port is both enabled and suspended.
- R7: Writing 1 to a change-flag bit clears that flag in the cycle of the write, even while busy. Writing 0 leaves the flag unchanged. A hardware set in the same cycle wins over the clear.
- R8: Whenever the reset-change flag becomes set, the resume-change flag is cleared.
- R9: With OC_PER_PORT = 1, every change of the overcurrent bit (bit 3) sets the overcurrent-change flag.
- R10: A command write made while xact_busy is high is deferred and applied on the first cycle in which busy is low. A later write while one is pending replaces the pending value.
- R11: When bit 0 falls, the port loses enable and suspend and any running sequence stops. If the port was enabled, the enable-change flag is set.
- R12: In idle, bit 1 set to 1 enables a connected port, bit 0 set to 1 disables the port, and bit 2 set to 1 suspends an enabled port. Command bits written while a sequence runs are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| xact_busy | input | 1 | Bus transaction in progress |
| line_connect | input | 1 | Device present on the port |
| line_lowspeed | input | 1 | Attached device is low speed |
| line_ovc | input | 1 | Overcurrent sensed on the port |
| wr_en | input | 1 | Status word write strobe |
| wdata | input | 32 | Write data (commands and flag clears) |
| status_word | output | 32 | Current status and change flags |
| reset_drive | output | 1 | Drive reset signalling on the port |
| resume_drive | output | 1 | Drive resume signalling on the port |
| eop_drive | output | 1 | Drive the low-speed end-of-packet |

## Verification
The assertions check these rules on every cycle:
- the three strobes stay mutually exclusive, and the end-of-packet follows resume signalling;
- a resume only starts from an enabled, suspended port;
- a completed reset leaves the port enabled with its flag set and the resume flag clear;
- a flag holds when no 1 is written to it;
- an overcurrent toggle raises its flag;
- while busy, neither power nor a new reset can start.

Only the bench scenarios show the following:
- the exact lengths of each timed phase;
- the replacement of a pending write by a later one;
- the abort on disconnect;
- that reserved bits read zero after an all-ones write.

// File: rtl/usbps_pkg.sv
package usbps_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_RESET  = 3'd1,
        SQ_RESUME = 3'd2,
        SQ_EOP    = 3'd3,
        SQ_RESYNC = 3'd4
    } seq_e;

    localparam int NFLAG     = 5;
    localparam int FLAG_BASE = 16;
    localparam int FL_CONN   = 0;
    localparam int FL_EN     = 1;
    localparam int FL_RSM    = 2;
    localparam int FL_OC     = 3;
    localparam int FL_RST    = 4;

    localparam int CMD_DISABLE = 0;
    localparam int CMD_ENABLE  = 1;
    localparam int CMD_SUSPEND = 2;
    localparam int CMD_RESUME  = 3;
    localparam int CMD_RESET   = 4;
    localparam int CMD_PWR_ON  = 8;
    localparam int CMD_PWR_OFF = 9;

    typedef struct packed {
        seq_e seq;
        logic en;
        logic susp;
        logic pwr;
        logic conn;
        logic oc;
        logic lowspd;
    } port_s;

endpackage

// File: rtl/usbps_ms_timer.sv
module usbps_ms_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    logic [CW-1:0] cnt_d, cnt_q;

    // Expiry looks only at the held count so restart cannot loop back into it
    assign expire = tick && (cnt_q == limit - 1'b1);

    always_comb begin
        cnt_d = cnt_q;
        if (restart) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/usbps_chg_flag.sv
module usbps_chg_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set) begin
            flag_d = 1'b1;
        end else if (clr) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag = flag_q;
endmodule

// File: rtl/usbps_wr_defer.sv
module usbps_wr_defer #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          busy,
    output logic          apply,
    output logic [DW-1:0] apply_data
);
    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } pend_s;

    pend_s pend_d, pend_q;

    assign apply      = !busy && (wr_en || pend_q.valid);
    assign apply_data = wr_en ? wdata : pend_q.data;

    always_comb begin
        pend_d = pend_q;
        if (busy && wr_en) begin
            pend_d.valid = 1'b1;
            pend_d.data  = wdata;
        end else if (apply) begin
            pend_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pend_d;
        end
    end
endmodule

// File: rtl/usb_port_status.sv
module usb_port_status
    import usbps_pkg::*;
#(
    parameter int RESET_MS    = 10,
    parameter int RESUME_MS   = 20,
    parameter int RESYNC_MS   = 3,
    parameter int EOP_CYC     = 2,
    parameter bit OC_PER_PORT = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ms_tick,
    input  logic        xact_busy,
    input  logic        line_connect,
    input  logic        line_lowspeed,
    input  logic        line_ovc,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] status_word,
    output logic        reset_drive,
    output logic        resume_drive,
    output logic        eop_drive
);
    localparam int DW      = 32;
    localparam int MAX_A   = (RESET_MS > RESUME_MS) ? RESET_MS : RESUME_MS;
    localparam int MAX_B   = (RESYNC_MS > EOP_CYC) ? RESYNC_MS : EOP_CYC;
    localparam int MAX_LIM = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW      = $clog2(MAX_LIM + 1) + 1;

    port_s cur_q, nx_d;

    logic             apply;
    logic [DW-1:0]    apply_data;
    logic             expire;
    logic             tmr_tick;
    logic             tmr_restart;
    logic [CW-1:0]    tmr_limit;
    logic             conn_new;
    logic             oc_evt;
    logic [NFLAG-1:0] flag_set;
    logic [NFLAG-1:0] flag_clr;
    logic [NFLAG-1:0] flags;

    usbps_wr_defer #(.DW(DW)) u_defer (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wdata      (wdata),
        .busy       (xact_busy),
        .apply      (apply),
        .apply_data (apply_data)
    );

    // End-of-packet phase counts clock cycles, the others count ms ticks
    assign tmr_tick = ms_tick || (cur_q.seq == SQ_EOP);

    always_comb begin
        case (cur_q.seq)
            SQ_RESET:  tmr_limit = CW'(RESET_MS);
            SQ_RESUME: tmr_limit = CW'(RESUME_MS);
            SQ_EOP:    tmr_limit = CW'(EOP_CYC);
            SQ_RESYNC: tmr_limit = CW'(RESYNC_MS);
            default:   tmr_limit = CW'(1);
        endcase
    end

    usbps_ms_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tmr_restart),
        .tick    (tmr_tick),
        .limit   (tmr_limit),
        .expire  (expire)
    );

    generate
        if (OC_PER_PORT) begin : g_oc_port
            assign oc_evt = (line_ovc != cur_q.oc);
        end else begin : g_oc_global
            assign oc_evt = 1'b0;
        end
    endgenerate

    assign conn_new = line_connect && cur_q.pwr;

    always_comb begin
        nx_d     = cur_q;
        flag_set = '0;

        // Timed sequence progress
        case (cur_q.seq)
            SQ_RESET: begin
                if (expire) begin
                    nx_d.seq          = SQ_IDLE;
                    nx_d.en           = 1'b1;
                    nx_d.susp         = 1'b0;
                    flag_set[FL_RST]  = 1'b1;
                end
            end
            SQ_RESUME: if (expire) nx_d.seq = SQ_EOP;
            SQ_EOP:    if (expire) nx_d.seq = SQ_RESYNC;
            SQ_RESYNC: begin
                if (expire) begin
                    nx_d.seq          = SQ_IDLE;
                    nx_d.susp         = 1'b0;
                    flag_set[FL_RSM]  = 1'b1;
                end
            end
            default: ;
        endcase

        // Port commands, only from idle
        if (apply && cur_q.seq == SQ_IDLE) begin
            if (apply_data[CMD_PWR_OFF]) begin
                nx_d.pwr = 1'b0;
            end else if (apply_data[CMD_PWR_ON]) begin
                nx_d.pwr = 1'b1;
            end
            if (apply_data[CMD_DISABLE]) nx_d.en = 1'b0;
            if (apply_data[CMD_ENABLE] && cur_q.conn) nx_d.en = 1'b1;
            if (apply_data[CMD_SUSPEND] && cur_q.en) nx_d.susp = 1'b1;
            if (apply_data[CMD_RESUME] && cur_q.en && cur_q.susp) begin
                nx_d.seq = SQ_RESUME;
            end
            if (apply_data[CMD_RESET] && cur_q.pwr && cur_q.conn) begin
                nx_d.seq = SQ_RESET;
            end
        end

        // Disconnect overrides everything
        if (cur_q.conn && !conn_new) begin
            nx_d.en          = 1'b0;
            nx_d.susp        = 1'b0;
            nx_d.seq         = SQ_IDLE;
            flag_set[FL_EN]  = cur_q.en;
        end

        flag_set[FL_CONN] = (conn_new != cur_q.conn);
        flag_set[FL_OC]   = oc_evt;
        nx_d.conn         = conn_new;
        nx_d.lowspd       = line_lowspeed && conn_new;
        nx_d.oc           = line_ovc;
    end

    assign tmr_restart = (nx_d.seq != cur_q.seq);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{seq: SQ_IDLE, default: 1'b0};
        end else begin
            cur_q <= nx_d;
        end
    end

    generate
        for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
            if (gi == FL_RSM) begin : g_rsm
                assign flag_clr[gi] = (wr_en && wdata[FLAG_BASE+gi]) || flag_set[FL_RST];
            end else begin : g_plain
                assign flag_clr[gi] = wr_en && wdata[FLAG_BASE+gi];
            end
            usbps_chg_flag u_flag (
                .clk   (clk),
                .rst_n (rst_n),
                .set   (flag_set[gi]),
                .clr   (flag_clr[gi]),
                .flag  (flags[gi])
            );
        end
    endgenerate

    assign reset_drive  = (cur_q.seq == SQ_RESET);
    assign resume_drive = (cur_q.seq == SQ_RESUME);
    assign eop_drive    = (cur_q.seq == SQ_EOP);

    assign status_word = {11'b0, flags, 6'b0, cur_q.lowspd, cur_q.pwr, 3'b0,
                          reset_drive, cur_q.oc, cur_q.susp, cur_q.en, cur_q.conn};
endmodule

// File: rtl/usb_port_status_chk.sv
module usb_port_status_chk #(
    parameter bit OC_PER_PORT = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [31:0] wdata,
    input logic        xact_busy,
    input logic [31:0] status_word,
    input logic        reset_drive,
    input logic        resume_drive,
    input logic        eop_drive
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reset_drive, resume_drive, eop_drive})); // R5

    AST_EOP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eop_drive) |-> $past(resume_drive)); // R5

    AST_RESET_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(reset_drive) && status_word[0] |-> status_word[20] && status_word[1] && !status_word[2]); // R4

    AST_RST_CLRS_RSM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_word[20]) |-> !status_word[18]); // R8

    AST_W0_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[16] && !(wr_en && wdata[16]) |=> status_word[16]); // R7

    AST_RESUME_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(resume_drive) |-> $past(status_word[1]) && $past(status_word[2])); // R6

    AST_BUSY_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        xact_busy |=> $stable(status_word[8])); // R10

    AST_BUSY_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        xact_busy && !reset_drive |=> !reset_drive); // R10

    AST_OC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        OC_PER_PORT && !$stable(status_word[3]) |-> status_word[19]); // R9
endmodule

bind usb_port_status usb_port_status_chk #(.OC_PER_PORT(OC_PER_PORT)) u_chk (.*);

// File: tb/usb_port_status_bench.sv
module usb_port_status_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T_RESET    = 4;
    localparam int T_RESUME   = 5;
    localparam int T_RESYNC   = 2;
    localparam int T_EOP      = 2;
    localparam int TICK_DIV   = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b0;
    logic        xact_busy = 1'b0;
    logic        line_connect = 1'b0;
    logic        line_lowspeed = 1'b0;
    logic        line_ovc = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] status_word;
    logic        reset_drive, resume_drive, eop_drive;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_port_status #(
        .RESET_MS(T_RESET), .RESUME_MS(T_RESUME), .RESYNC_MS(T_RESYNC),
        .EOP_CYC(T_EOP), .OC_PER_PORT(1'b1)
    ) u_usb_port_status (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .xact_busy(xact_busy),
        .line_connect(line_connect), .line_lowspeed(line_lowspeed), .line_ovc(line_ovc),
        .wr_en(wr_en), .wdata(wdata), .status_word(status_word),
        .reset_drive(reset_drive), .resume_drive(resume_drive), .eop_drive(eop_drive)
    );

    // Millisecond tick generator
    int tick_cnt = 0;
    always @(negedge clk) begin
        tick_cnt = (tick_cnt + 1) % TICK_DIV;
        ms_tick <= (tick_cnt == 0);
    end

    // Behavioural reference model: phase 0 idle, 1 reset, 2 resume, 3 eop, 4 resync
    int m_ph, m_cnt, o_ph, m_lim;
    bit m_en, m_su, m_pw, m_cn, m_oc, m_ls;
    bit m_fl[5];
    bit m_set[5];
    bit m_clr[5];
    bit m_pend, m_ap, m_tk, m_exp, n_cn;
    logic [31:0] m_pd, m_ad;
    bit o_en, o_su, o_pw, o_cn;

    function automatic int phase_len(int ph);
        case (ph)
            1: return T_RESET;
            2: return T_RESUME;
            3: return T_EOP;
            4: return T_RESYNC;
            default: return 1;
        endcase
    endfunction

    function automatic logic [31:0] model_word();
        logic [31:0] w = '0;
        w[0] = m_cn; w[1] = m_en; w[2] = m_su; w[3] = m_oc; w[4] = (m_ph == 1);
        w[8] = m_pw; w[9] = m_ls;
        for (int i = 0; i < 5; i++) w[16+i] = m_fl[i];
        return w;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_en = 0; m_su = 0; m_pw = 0; m_cn = 0; m_oc = 0; m_ls = 0;
            m_pend = 0; m_pd = '0;
            for (int i = 0; i < 5; i++) m_fl[i] = 0;
        end else begin
            o_ph = m_ph; o_en = m_en; o_su = m_su; o_pw = m_pw; o_cn = m_cn;
            for (int i = 0; i < 5; i++) m_set[i] = 0;
            m_ap = !xact_busy && (wr_en || m_pend);
            m_ad = wr_en ? wdata : m_pd;
            if (xact_busy && wr_en) begin m_pend = 1; m_pd = wdata; end
            else if (m_ap) m_pend = 0;
            m_tk = ms_tick || (o_ph == 3);
            m_lim = phase_len(o_ph);
            m_exp = m_tk && (m_cnt == m_lim - 1);
            if (m_exp) begin
                if (o_ph == 1) begin m_ph = 0; m_en = 1; m_su = 0; m_set[4] = 1; end
                else if (o_ph == 2) m_ph = 3;
                else if (o_ph == 3) m_ph = 4;
                else if (o_ph == 4) begin m_ph = 0; m_su = 0; m_set[2] = 1; end
            end
            if (m_ap && o_ph == 0) begin
                if (m_ad[9]) m_pw = 0; else if (m_ad[8]) m_pw = 1;
                if (m_ad[0]) m_en = 0;
                if (m_ad[1] && o_cn) m_en = 1;
                if (m_ad[2] && o_en) m_su = 1;
                if (m_ad[3] && o_en && o_su) m_ph = 2;
                if (m_ad[4] && o_pw && o_cn) m_ph = 1;
            end
            n_cn = line_connect && o_pw;
            if (o_cn && !n_cn) begin
                m_en = 0; m_su = 0; m_ph = 0; m_set[1] = o_en;
            end
            m_set[0] = (n_cn != o_cn);
            m_set[3] = (line_ovc != m_oc);
            m_cn = n_cn; m_ls = line_lowspeed && n_cn; m_oc = line_ovc;
            for (int i = 0; i < 5; i++) m_clr[i] = wr_en && wdata[16+i];
            m_clr[2] = m_clr[2] || m_set[4];
            for (int i = 0; i < 5; i++) m_fl[i] = m_set[i] || (m_fl[i] && !m_clr[i]);
            if (m_ph != o_ph) m_cnt = 0; else if (m_tk) m_cnt = m_cnt + 1;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [31:0] exp_w;
            exp_w = model_word();
            checks++;
            if (status_word !== exp_w || reset_drive !== (m_ph == 1) ||
                resume_drive !== (m_ph == 2) || eop_drive !== (m_ph == 3)) begin
                errors++;
                $display("FAIL %s model: word %h drv %b%b%b expected word %h drv %b%b%b",
                         cur_req, status_word, reset_drive, resume_drive, eop_drive,
                         exp_w, m_ph == 1, m_ph == 2, m_ph == 3);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    initial begin
        int eop_len;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        cur_req = "R1";
        check("R1 reset word", status_word, 32'h0);
        check("R1 reset strobes", {reset_drive, resume_drive, eop_drive}, 0);

        cur_req = "R2";
        line_connect = 1'b1; line_lowspeed = 1'b1;
        cyc(3);
        check("R2 unpowered connect", status_word[0], 0);

        cur_req = "R3";
        wr(32'h0000_0100);
        cyc(3);
        check("R3 powered", status_word[8], 1);
        check("R2 connect seen", status_word[0], 1);
        check("R2 connect change", status_word[16], 1);
        check("R2 low speed", status_word[9], 1);

        cur_req = "R7";
        wr(32'h0000_0000);
        cyc(1);
        check("R7 write 0 keeps flag", status_word[16], 1);
        wr(32'h0001_0000);
        cyc(1);
        check("R7 write 1 clears flag", status_word[16], 0);

        cur_req = "R6";
        wr(32'h0000_0008);
        cyc(2);
        check("R6 resume ignored", {resume_drive, status_word[2]}, 0);

        cur_req = "R4";
        wr(32'h0000_0010);
        cyc(1);
        check("R4 reset active", {reset_drive, status_word[4]}, 2'b11);
        cur_req = "R12";
        wr(32'h0000_0200);
        cur_req = "R4";
        cyc(30);
        check("R12 power-off dropped during reset", status_word[8], 1);
        check("R4 reset ended", status_word[4], 0);
        check("R4 enabled after reset", status_word[1], 1);
        check("R4 reset change flag", status_word[20], 1);

        cur_req = "R12";
        wr(32'h0000_0004);
        cyc(1);
        check("R12 suspend", status_word[2], 1);

        cur_req = "R5";
        wr(32'h0000_0008);
        cyc(1);
        check("R5 resume strobe", resume_drive, 1);
        eop_len = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (eop_drive) eop_len++;
        end
        check("R5 eop length", eop_len, T_EOP);
        check("R5 suspend cleared", status_word[2], 0);
        check("R5 resume flag", status_word[18], 1);

        cur_req = "R8";
        wr(32'h0010_0000);
        wr(32'h0000_0010);
        cyc(30);
        check("R8 reset flag set", status_word[20], 1);
        check("R8 resume flag cleared", status_word[18], 0);

        cur_req = "R10";
        xact_busy = 1'b1;
        wr(32'h0000_0004);
        wr(32'h0010_0000);
        wr(32'h0000_0001);
        cyc(2);
        check("R7 clear while busy", status_word[20], 0);
        check("R10 held while busy", status_word[2:1], 2'b01);
        xact_busy = 1'b0;
        cyc(2);
        check("R10 replaced write applied", status_word[2:1], 2'b00);

        cur_req = "R9";
        line_ovc = 1'b1;
        cyc(2);
        check("R9 overcurrent bit", status_word[3], 1);
        check("R9 overcurrent change", status_word[19], 1);
        wr(32'h0008_0000);
        line_ovc = 1'b0;
        cyc(2);
        check("R9 change on fall", status_word[19], 1);

        cur_req = "R11";
        wr(32'h0000_0002);
        wr(32'h0000_0004);
        wr(32'h0000_0008);
        cyc(3);
        line_connect = 1'b0;
        cyc(3);
        check("R11 resume aborted", resume_drive, 0);
        check("R11 enable/suspend lost", status_word[2:1], 2'b00);
        check("R11 enable change", status_word[17], 1);
        check("R11 connect change", status_word[16], 1);

        cur_req = "R1";
        line_connect = 1'b1;
        wr(32'hFFFF_FFFF);
        cyc(2);
        check("R1 reserved zero", status_word & 32'hFFE0_FCE0, 32'h0);
        check("R3 power off wins", status_word[8], 0);

        cyc(4);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule